// File: doc/BRIEF.md
# Transmit-Path Interrupt Register Bank

This block collects interrupt requests for one framer and presents them to a processor as a single active-high `irq` line. Two gating levels apply. A section-level register holds one enable per section: receive, transmit and one-second. A message register holds the transmit completion source: its own enable, a sticky pending flag, a start command and a busy indicator. A request reaches `irq` only when its section enable is set. The transmit completion request also needs its own source enable.

The processor uses a synchronous bus with address, write data, write strobe and read strobe. Read data is registered and appears one cycle after the read strobe. The message transmitter reports the end of a message with a one-cycle `msg_done` pulse. That pulse moves a two-state status machine from `ST_CLEAR` to `ST_PENDING` (transition *raise*). A read of the message register moves it back (transition *acknowledge*), unless a new pulse arrives in the same cycle (transition *hold*, which stays in `ST_PENDING`). The receive and one-second sections sit outside the block. Their requests arrive as the `rx_req` and `sec_req` inputs.

Top module: `txirq_bank`

## Requirements
- R1: After reset, every writable bit is 0, the status machine is in `ST_CLEAR`, `irq` is 0, `msg_go` is 0 and `bus_rdata` is 0.
- R2: The section enable register is at address 0x04. Bit 7 is the receive enable, bit 1 the transmit enable and bit 0 the one-second enable, all read/write. Bits 6 to 2 always read 0, whatever was written.
- R3: The message register is at address 0x34. Bit 3 is a read/write start command, driven on `msg_go`. Bit 2 reads the `msg_busy` input. Bit 1 is the read/write completion source enable. Bit 0 is the pending flag. Bits 7 to 4 read 0.
- R4: A `msg_done` pulse sets the pending flag even when the section enable or the source enable is 0.
- R5: A read of 0x34 returns the pending flag as it was before the read, then clears it. A read of 0x04 leaves the flag alone. A write to 0x34 never changes bit 0.
- R6: When `msg_done` and a read of 0x34 fall in the same cycle, the flag stays 1.
- R7: When the transmit section enable (0x04 bit 1) is 0, the pending flag never drives `irq`, whatever the source enable holds.
- R8: When the transmit section enable and the source enable are both 1, `irq` is 1 whenever the flag is pending. With the source enable at 0, the flag does not drive `irq`.
- R9: `rx_req` reaches `irq` only while 0x04 bit 7 is 1. `sec_req` reaches `irq` only while 0x04 bit 0 is 1.
- R10: `bus_rdata` changes only in the cycle after a read strobe. A read of any other address returns 0. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| msg_done | input | 1 | One-cycle completion pulse from the message transmitter |
| msg_busy | input | 1 | Transmitter busy level |
| msg_go | output | 1 | Start command to the transmitter |
| rx_req | input | 1 | Receive-section request |
| sec_req | input | 1 | One-second request |
| irq | output | 1 | Interrupt output, active high |

## Verification
Directed sequences drive the completion pulse under each of the four enable combinations. This shows whether the section enable masks the source enable, or only the source enable is checked. A pulse that coincides with a read of 0x34 separates the *hold* transition from *acknowledge*. Back-to-back reads show whether a read clears the flag, and whether a read of 0x04 leaves it alone. A long random mix of writes, reads, pulses, busy levels and outside requests, including unmapped addresses, is compared against a behavioural model on every clock. That run exposes gating, read-mux or write-decode slips that the directed cases miss.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
    localparam int DATA_W = 8;

    // section enable register bit positions
    localparam int SEC_RX_BIT  = 7;
    localparam int SEC_TX_BIT  = 1;
    localparam int SEC_ONE_BIT = 0;

    // message register bit positions
    localparam int MSG_GO_BIT   = 3;
    localparam int MSG_BUSY_BIT = 2;
    localparam int MSG_IEN_BIT  = 1;
    localparam int MSG_PEND_BIT = 0;

    // interrupt source indices
    localparam int SRC_TX  = 0;
    localparam int SRC_RX  = 1;
    localparam int SRC_ONE = 2;
    localparam int NSRC    = 3;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_PENDING = 1'b1
    } pend_state_e;
endpackage

// File: rtl/txirq_pend_fsm.sv
module txirq_pend_fsm
    import txirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic pending
);
    pend_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:   if (raise) state_d = ST_PENDING;
            ST_PENDING: if (ack && !raise) state_d = ST_CLEAR;
            default:    state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        pending = (state_q == ST_PENDING);
    end

    a_r4_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> pending);
    a_r6_hold_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (raise && ack) |=> pending);
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !raise) |=> !pending);
endmodule

// File: rtl/txirq_regfile.sv
module txirq_regfile
    import txirq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SEC_ADDR = 8'h04,
    parameter logic [ADDR_W-1:0] MSG_ADDR = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic              pending,
    input  logic              busy,
    output logic [NSRC-1:0]   sec_en,
    output logic              src_ien,
    output logic              go,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    logic sel_sec, sel_msg;
    logic [DATA_W-1:0] rd_mux;
    logic unused_wdata;

    assign sel_sec = (addr == SEC_ADDR);
    assign sel_msg = (addr == MSG_ADDR);
    assign ack     = rd && sel_msg;
    assign unused_wdata = ^{wdata[6:4], wdata[2], wdata[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_en  <= '0;
            src_ien <= 1'b0;
            go      <= 1'b0;
        end else if (wr) begin
            if (sel_sec) begin
                sec_en[SRC_RX]  <= wdata[SEC_RX_BIT];
                sec_en[SRC_TX]  <= wdata[SEC_TX_BIT];
                sec_en[SRC_ONE] <= wdata[SEC_ONE_BIT];
            end
            if (sel_msg) begin
                go      <= wdata[MSG_GO_BIT];
                src_ien <= wdata[MSG_IEN_BIT];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel_sec) begin
            rd_mux[SEC_RX_BIT]  = sec_en[SRC_RX];
            rd_mux[SEC_TX_BIT]  = sec_en[SRC_TX];
            rd_mux[SEC_ONE_BIT] = sec_en[SRC_ONE];
        end else if (sel_msg) begin
            rd_mux[MSG_GO_BIT]   = go;
            rd_mux[MSG_BUSY_BIT] = busy;
            rd_mux[MSG_IEN_BIT]  = src_ien;
            rd_mux[MSG_PEND_BIT] = pending;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel_sec) |=> (rdata[6:2] == 5'd0));
    a_r3_busy_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel_msg) |=> (rdata[MSG_BUSY_BIT] == $past(busy)));
    a_r10_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/txirq_combine.sv
module txirq_combine
    import txirq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] blk_en,
    output logic            irq
);
    logic [NSRC-1:0] gated;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign gated[i] = req[i] & src_en[i] & blk_en[i];
    end

    assign irq = |gated;
endmodule

// File: rtl/txirq_bank.sv
module txirq_bank
    import txirq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SEC_ADDR = 8'h04,
    parameter logic [ADDR_W-1:0] MSG_ADDR = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              msg_done,
    input  logic              msg_busy,
    output logic              msg_go,
    input  logic              rx_req,
    input  logic              sec_req,
    output logic              irq
);
    logic [NSRC-1:0] sec_en, req_v, src_en_v;
    logic src_ien, ack, pending;

    txirq_pend_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .raise(msg_done), .ack(ack), .pending(pending)
    );

    txirq_regfile #(.ADDR_W(ADDR_W), .SEC_ADDR(SEC_ADDR), .MSG_ADDR(MSG_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .wr(bus_wr), .rd(bus_rd), .pending(pending), .busy(msg_busy),
        .sec_en(sec_en), .src_ien(src_ien), .go(msg_go), .ack(ack),
        .rdata(bus_rdata)
    );

    always_comb begin
        req_v = '0;
        src_en_v = '1;
        req_v[SRC_TX]    = pending;
        req_v[SRC_RX]    = rx_req;
        req_v[SRC_ONE]   = sec_req;
        src_en_v[SRC_TX] = src_ien;
    end

    txirq_combine u_comb (
        .req(req_v), .src_en(src_en_v), .blk_en(sec_en), .irq(irq)
    );

    a_r7_section_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_en[SRC_TX] && !(rx_req && sec_en[SRC_RX]) && !(sec_req && sec_en[SRC_ONE]))
        |-> !irq);
    a_r8_both_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && src_ien && sec_en[SRC_TX]) |-> irq);
    a_r9_rx_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && sec_en[SRC_RX]) |-> irq);
endmodule

// File: tb/txirq_bank_test.sv
module txirq_bank_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic msg_done = 1'b0, msg_busy = 1'b0, rx_req = 1'b0, sec_req = 1'b0;
    logic msg_go, irq;

    int tests = 0;
    int fails = 0;
    bit cmp_on = 1'b0;

    // behavioural reference state
    bit m_rx, m_tx, m_one, m_ien, m_go, m_pend;
    logic [7:0] m_rdata;

    always #5 clk = ~clk;

    txirq_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .msg_done(msg_done), .msg_busy(msg_busy), .msg_go(msg_go),
        .rx_req(rx_req), .sec_req(sec_req), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rx <= 0; m_tx <= 0; m_one <= 0; m_ien <= 0; m_go <= 0; m_pend <= 0;
            m_rdata <= 8'h00;
        end else begin
            if (bus_rd) begin
                if (bus_addr == 8'h04)      m_rdata <= {m_rx, 5'b0, m_tx, m_one};
                else if (bus_addr == 8'h34) m_rdata <= {4'b0, m_go, msg_busy, m_ien, m_pend};
                else                        m_rdata <= 8'h00;
            end
            if (bus_wr && bus_addr == 8'h04) begin
                m_rx <= bus_wdata[7]; m_tx <= bus_wdata[1]; m_one <= bus_wdata[0];
            end
            if (bus_wr && bus_addr == 8'h34) begin
                m_go <= bus_wdata[3]; m_ien <= bus_wdata[1];
            end
            if (msg_done) m_pend <= 1;
            else if (bus_rd && bus_addr == 8'h34) m_pend <= 0;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_irq();
        return (m_pend && m_ien && m_tx) || (rx_req && m_rx) || (sec_req && m_one);
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R7/R8/R9 irq", {7'b0, irq}, {7'b0, exp_irq()});
            check("R2/R3/R5/R10 rdata", bus_rdata, m_rdata);
            check("R3 msg_go", {7'b0, msg_go}, {7'b0, m_go});
        end
    end

    task automatic step(input logic [7:0] a, input logic [7:0] d, input bit w, input bit r, input bit done);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r; msg_done = done;
    endtask

    task automatic idle();
        step(8'h00, 8'h00, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        check("R1 rdata after reset", bus_rdata, 8'h00);
        check("R1 go after reset", {7'b0, msg_go}, 8'h00);
        cmp_on = 1'b1;

        // R2: reserved bits read zero
        step(8'h04, 8'hFF, 1, 0, 0);
        step(8'h04, 8'h00, 0, 1, 0);
        idle(); @(negedge clk);
        check("R2 reserved bits", bus_rdata, 8'h83);

        // R4: pulse with enables off still sets pending; R7 no irq
        step(8'h04, 8'h00, 1, 0, 0);
        step(8'h00, 8'h00, 0, 0, 1);
        idle(); @(negedge clk);
        check("R7 masked irq", {7'b0, irq}, 8'h00);
        // R8: source enable on, section enable off -> still masked
        step(8'h34, 8'h02, 1, 0, 0);
        idle(); @(negedge clk);
        check("R7 section mask over source", {7'b0, irq}, 8'h00);
        step(8'h04, 8'h02, 1, 0, 0);
        idle(); @(negedge clk);
        check("R8 irq both enabled", {7'b0, irq}, 8'h01);
        // R5: read 0x04 does not clear
        step(8'h04, 8'h00, 0, 1, 0);
        idle(); @(negedge clk);
        check("R5 irq after 0x04 read", {7'b0, irq}, 8'h01);
        // R5: read 0x34 returns pending, then clears
        msg_busy = 1'b1;
        step(8'h34, 8'h00, 0, 1, 0);
        idle(); @(negedge clk);
        check("R4 pending seen, R3 busy", bus_rdata, 8'h07);
        check("R5 irq cleared", {7'b0, irq}, 8'h00);
        msg_busy = 1'b0;
        step(8'h34, 8'h00, 0, 1, 0);
        idle(); @(negedge clk);
        check("R5 second read zero", bus_rdata, 8'h02);
        // R6: pulse coincides with read
        step(8'h34, 8'h00, 0, 1, 1);
        idle(); @(negedge clk);
        check("R6 hold irq", {7'b0, irq}, 8'h01);
        // R5: write to bit0 cannot clear
        step(8'h34, 8'h0A, 1, 0, 0);
        idle(); @(negedge clk);
        check("R5 write ignores status", {7'b0, irq}, 8'h01);
        check("R3 go driven", {7'b0, msg_go}, 8'h01);
        // R8: source enable off hides pending
        step(8'h34, 8'h00, 1, 0, 0);
        idle(); @(negedge clk);
        check("R8 source disabled", {7'b0, irq}, 8'h00);
        // R9 outside requests
        rx_req = 1'b1;
        idle(); @(negedge clk);
        check("R9 rx masked", {7'b0, irq}, 8'h00);
        step(8'h04, 8'h80, 1, 0, 0);
        idle(); @(negedge clk);
        check("R9 rx passes", {7'b0, irq}, 8'h01);
        rx_req = 1'b0;
        // R10 unmapped
        step(8'h35, 8'hFF, 1, 1, 0);
        idle(); @(negedge clk);
        check("R10 unmapped read", bus_rdata, 8'h00);
        step(8'h04, 8'h00, 0, 1, 0);
        idle(); @(negedge clk);
        check("R10 unmapped write", bus_rdata, 8'h80);

        // random mix, compared every clock
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            int k = $urandom_range(0, 3);
            a = (k == 0) ? 8'h04 : (k == 1) ? 8'h34 : (k == 2) ? 8'h00 : 8'h35;
            rx_req = ($urandom_range(0, 3) == 0);
            sec_req = ($urandom_range(0, 3) == 0);
            msg_busy = $urandom_range(0, 1);
            step(a, 8'($urandom), ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 2) == 0), ($urandom_range(0, 5) == 0));
        end
        idle(); @(negedge clk);
        cmp_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule